// File: doc/BRIEF.md
# Frame window address generator

This block produces the sequence of memory word addresses for a DMA transfer over a two-dimensional picture held in frame memory. The picture width and height, a signed picture start position, the frame memory base, the transfer extent and the addressing mode are presented as steady configuration inputs. A one-cycle `start` pulse launches a transfer. The block then offers one address per accepted handshake on its output until the final word, which it marks with `out_last`.

In block addressing the generator walks a window of (ext_w+1) columns by (ext_h+1) rows in row-major order. In linear addressing it emits a run of consecutive addresses. An unrestricted option clamps picture coordinates that fall outside the picture onto the nearest edge pixel. The current row, column and remaining word count are brought out. A service cut short by `stop` can therefore be saved and later continued with `resume`.

The control is a three-state machine. IDLE moves to SETUP on `start`, or on `resume` with a nonzero saved count. SETUP always moves to EMIT one cycle later, after it has formed the row base address. EMIT returns to IDLE on `stop`, or when the word flagged last is accepted. While `out_rdy` is low in EMIT, the state and all outputs hold.

Top module: `fwin_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` and `busy` are 0 and `words_left` is 0.
- R2: `xfer_size` equals (ext_w+1)*(ext_h+1) when `lin_mode`=0 (block) and ext_h*512+(ext_w+1) when `lin_mode`=1 (linear), combinationally from the inputs.
- R3: A `start` pulse sampled in IDLE gives `busy`=1 with `out_valid`=0 in the next cycle. It gives `out_valid`=1 in the cycle after that, with a first address of fm_base*16 + pos_y*(pic_w+1) + pos_x.
- R4: In block mode, word i is at row i/(ext_w+1) and column i mod (ext_w+1). Addresses rise by 1 within a row, and the first word of the next row lies (pic_w+1)-ext_w above the last word of the previous row.
- R5: In linear mode, word i is at the first address plus i, for `xfer_size` words.
- R6: `out_last` is 1 exactly on the final word of the transfer and never without `out_valid`. Once that word is accepted, `busy` is 0 in the next cycle.
- R7: While `out_valid`=1 and `out_rdy`=0, the next cycle keeps `out_valid`, `out_addr` and `out_last` unchanged.
- R8: With `unrestricted`=1, the x coordinate (pos_x plus column, two's complement) is clamped to [0, pic_w] and the y coordinate to [0, pic_h] before the address is formed. In linear mode only the start point is clamped.
- R9: `cur_row`, `cur_col` and `words_left` give the row, column (the word index in linear mode) and remaining word count of the word currently offered. `words_left` falls by one per accepted word.
- R10: `stop` in EMIT returns to IDLE without transferring the offered word, keeping `cur_row`, `cur_col` and `words_left`. A later `resume` reloads them from `rsm_row`, `rsm_col` and `rsm_left` and continues the same address sequence. A `resume` with `rsm_left`=0 is ignored.
- R11: `start` and `resume` are ignored while `busy`=1.
- R12: With `unrestricted`=0, coordinates are not clamped, so a window wider than the picture runs on into the following picture row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new transfer (pulse, IDLE only) |
| resume | input | 1 | Continue a saved transfer from rsm_* (pulse, IDLE only) |
| stop | input | 1 | End the current service without transferring the offered word |
| lin_mode | input | 1 | 0 block addressing, 1 linear addressing |
| unrestricted | input | 1 | 1 clamps out-of-picture coordinates to the edge |
| pic_w | input | CW | Picture width minus one |
| pic_h | input | CW | Picture height minus one |
| pos_x | input | CW+1 | Signed picture start column |
| pos_y | input | CW+1 | Signed picture start row |
| ext_w | input | CW | Window width minus one |
| ext_h | input | CW | Window height minus one (row count field in linear mode) |
| fm_base | input | BW | Frame memory base in 16-word units |
| rsm_row | input | CW | Saved row for resume |
| rsm_col | input | SW | Saved column or word index for resume |
| rsm_left | input | SW | Saved remaining word count for resume |
| out_rdy | input | 1 | Downstream accepts the offered address |
| out_valid | output | 1 | An address is offered |
| out_addr | output | AW | Word address |
| out_last | output | 1 | Offered address is the final one |
| xfer_size | output | SW | Total words of the configured transfer |
| busy | output | 1 | Not in IDLE |
| cur_row | output | CW | Current row |
| cur_col | output | SW | Current column or linear word index |
| words_left | output | SW | Words remaining, including the offered one |

## Verification
A wrong row base or a faulty clamp first shows up when a row boundary is crossed: the first address of the next row is off. The bench compares every address against a closed-form model, so a bad internal value is caught on the first word it affects, at most ext_w+1 words into the window. A miscounted remaining value shows as `out_last` on the wrong word, or as `busy` staying high one cycle after the final acceptance. A save-and-restore fault shows on the first address after `resume`, two cycles after the pulse.

// File: rtl/fwin_pkg.sv
package fwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_EMIT  = 2'd2
    } fwin_state_e;

endpackage

// File: rtl/fwin_clamp.sv
// Saturates a signed coordinate into [0, lim] when enabled.
module fwin_clamp #(
    parameter int CW = 10,
    parameter int VW = 12
) (
    input  logic                 en,
    input  logic [CW-1:0]        lim,
    input  logic signed [VW-1:0] val,
    output logic signed [VW-1:0] res
);
    localparam logic signed [VW-1:0] ZERO_V = '0;

    logic signed [VW-1:0] lim_s;

    always_comb begin
        lim_s = $signed({{(VW-CW){1'b0}}, lim});
        if (!en) begin
            res = val;
        end else if (val < ZERO_V) begin
            res = ZERO_V;
        end else if (val > lim_s) begin
            res = lim_s;
        end else begin
            res = val;
        end
    end
endmodule

// File: rtl/fwin_size.sv
// Word count of a transfer for both addressing modes.
module fwin_size #(
    parameter int CW        = 10,
    parameter int SW        = 22,
    parameter int LIN_SHIFT = 9
) (
    input  logic [CW-1:0] ext_w,
    input  logic [CW-1:0] ext_h,
    input  logic          lin,
    output logic [SW-1:0] size
);
    logic [SW-1:0] ew1;
    logic [SW-1:0] eh1;
    logic [SW-1:0] eh_raw;

    always_comb begin
        ew1    = {{(SW-CW){1'b0}}, ext_w} + SW'(1);
        eh1    = {{(SW-CW){1'b0}}, ext_h} + SW'(1);
        eh_raw = {{(SW-CW){1'b0}}, ext_h};
        if (lin) begin
            size = (eh_raw << LIN_SHIFT) + ew1;
        end else begin
            size = ew1 * eh1;
        end
    end
endmodule

// File: rtl/fwin_origin.sv
// Address of column zero of a picture row: scaled base plus row offset.
module fwin_origin #(
    parameter int CW         = 10,
    parameter int VW         = 12,
    parameter int BW         = 12,
    parameter int AW         = 24,
    parameter int BASE_SHIFT = 4
) (
    input  logic [BW-1:0]        fm_base,
    input  logic [CW-1:0]        pic_w,
    input  logic signed [VW-1:0] y_row,
    output logic signed [AW-1:0] row_base
);
    logic signed [AW-1:0] base_a;
    logic signed [AW-1:0] y_a;
    logic signed [AW-1:0] pitch_a;

    always_comb begin
        base_a   = $signed({{(AW-BW){1'b0}}, fm_base}) <<< BASE_SHIFT;
        y_a      = {{(AW-VW){y_row[VW-1]}}, y_row};
        pitch_a  = $signed({{(AW-CW){1'b0}}, pic_w}) + $signed(AW'(1));
        row_base = base_a + y_a * pitch_a;
    end
endmodule

// File: rtl/fwin_addr_gen.sv
module fwin_addr_gen
    import fwin_pkg::*;
#(
    parameter int CW         = 10,
    parameter int BW         = 12,
    parameter int AW         = 24,
    parameter int BASE_SHIFT = 4,
    parameter int LIN_SHIFT  = 9,
    parameter int SW         = 2 * CW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 resume,
    input  logic                 stop,
    input  logic                 lin_mode,
    input  logic                 unrestricted,
    input  logic [CW-1:0]        pic_w,
    input  logic [CW-1:0]        pic_h,
    input  logic signed [CW:0]   pos_x,
    input  logic signed [CW:0]   pos_y,
    input  logic [CW-1:0]        ext_w,
    input  logic [CW-1:0]        ext_h,
    input  logic [BW-1:0]        fm_base,
    input  logic [CW-1:0]        rsm_row,
    input  logic [SW-1:0]        rsm_col,
    input  logic [SW-1:0]        rsm_left,
    input  logic                 out_rdy,
    output logic                 out_valid,
    output logic [AW-1:0]        out_addr,
    output logic                 out_last,
    output logic [SW-1:0]        xfer_size,
    output logic                 busy,
    output logic [CW-1:0]        cur_row,
    output logic [SW-1:0]        cur_col,
    output logic [SW-1:0]        words_left
);
    localparam int VW = CW + 2;
    localparam logic signed [VW-1:0] ONE_V = VW'(1);

    fwin_state_e state_q, state_d;

    logic [CW-1:0]        row_q;
    logic [SW-1:0]        col_q;
    logic [SW-1:0]        left_q;
    logic signed [AW-1:0] rbase_q;
    logic signed [VW-1:0] xs0_q;

    logic                 resume_ok;
    logic                 accept;
    logic                 final_word;
    logic                 row_end;
    logic                 step_row;
    logic signed [VW-1:0] y_cur, y_nxt, y_eff;
    logic signed [VW-1:0] x_blk, x_eff, x_sta, xs_eff;
    logic signed [VW-1:0] pic_h_s;
    logic signed [AW-1:0] rbase_calc;
    logic signed [AW-1:0] pitch;
    logic signed [AW-1:0] addr_s;
    logic [SW-1:0]        size_w;

    // ---------------- sub-blocks ----------------
    fwin_size #(.CW(CW), .SW(SW), .LIN_SHIFT(LIN_SHIFT)) u_size (
        .ext_w (ext_w),
        .ext_h (ext_h),
        .lin   (lin_mode),
        .size  (size_w)
    );

    fwin_clamp #(.CW(CW), .VW(VW)) u_clamp_y (
        .en  (unrestricted),
        .lim (pic_h),
        .val (y_cur),
        .res (y_eff)
    );

    fwin_clamp #(.CW(CW), .VW(VW)) u_clamp_x (
        .en  (unrestricted),
        .lim (pic_w),
        .val (x_blk),
        .res (x_eff)
    );

    fwin_clamp #(.CW(CW), .VW(VW)) u_clamp_s (
        .en  (unrestricted),
        .lim (pic_w),
        .val (x_sta),
        .res (xs_eff)
    );

    fwin_origin #(.CW(CW), .VW(VW), .BW(BW), .AW(AW), .BASE_SHIFT(BASE_SHIFT)) u_origin (
        .fm_base  (fm_base),
        .pic_w    (pic_w),
        .y_row    (y_eff),
        .row_base (rbase_calc)
    );

    // ---------------- coordinate arithmetic ----------------
    always_comb begin
        y_cur    = $signed({pos_y[CW], pos_y}) + $signed({2'b00, row_q});
        y_nxt    = y_cur + ONE_V;
        pic_h_s  = $signed({2'b00, pic_h});
        x_blk    = $signed({pos_x[CW], pos_x}) + $signed({2'b00, col_q[CW-1:0]});
        x_sta    = $signed({pos_x[CW], pos_x});
        pitch    = $signed({{(AW-CW){1'b0}}, pic_w}) + $signed(AW'(1));
        step_row = !unrestricted || ((y_nxt >= ONE_V) && (y_nxt <= pic_h_s));
        row_end  = (col_q[CW-1:0] == ext_w);
        if (lin_mode) begin
            addr_s = rbase_q + {{(AW-VW){xs0_q[VW-1]}}, xs0_q}
                             + $signed({{(AW-SW){1'b0}}, col_q});
        end else begin
            addr_s = rbase_q + {{(AW-VW){x_eff[VW-1]}}, x_eff};
        end
    end

    assign resume_ok  = resume && (rsm_left != '0);
    assign final_word = (left_q == SW'(1));
    assign accept     = (state_q == ST_EMIT) && out_rdy && !stop;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start || resume_ok) state_d = ST_SETUP;
            ST_SETUP: state_d = ST_EMIT;
            ST_EMIT: begin
                if (stop)                          state_d = ST_IDLE;
                else if (out_rdy && final_word)    state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- walk registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            left_q  <= '0;
            rbase_q <= '0;
            xs0_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        row_q  <= '0;
                        col_q  <= '0;
                        left_q <= size_w;
                    end else if (resume_ok) begin
                        row_q  <= rsm_row;
                        col_q  <= rsm_col;
                        left_q <= rsm_left;
                    end
                end
                ST_SETUP: begin
                    rbase_q <= rbase_calc;
                    xs0_q   <= xs_eff;
                end
                ST_EMIT: begin
                    if (accept) begin
                        left_q <= left_q - SW'(1);
                        if (lin_mode) begin
                            col_q <= col_q + SW'(1);
                        end else if (row_end) begin
                            col_q <= '0;
                            row_q <= row_q + CW'(1);
                            if (step_row) rbase_q <= rbase_q + pitch;
                        end else begin
                            col_q <= col_q + SW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        out_valid  = (state_q == ST_EMIT);
        out_last   = out_valid && final_word;
        busy       = (state_q != ST_IDLE);
        out_addr   = addr_s;
        xfer_size  = size_w;
        cur_row    = row_q;
        cur_col    = col_q;
        words_left = left_q;
    end

endmodule

// File: rtl/fwin_addr_gen_chk.sv
module fwin_addr_gen_chk #(
    parameter int CW = 10,
    parameter int AW = 24,
    parameter int SW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          stop,
    input logic          lin_mode,
    input logic          unrestricted,
    input logic          out_rdy,
    input logic          out_valid,
    input logic [AW-1:0] out_addr,
    input logic          out_last,
    input logic          busy,
    input logic [CW-1:0] ext_w,
    input logic [SW-1:0] cur_col,
    input logic [SW-1:0] words_left
);
    logic acc;
    assign acc = out_valid && out_rdy && !stop;

    // R6
    last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R7
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_rdy && !stop) |=>
            (out_valid && $stable(out_addr) && $stable(out_last)));

    // R6
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && out_last) |=> !busy);

    // R9
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !out_last) |=> (words_left == $past(words_left) - SW'(1)));

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !out_last && lin_mode) |=> (out_addr == $past(out_addr) + AW'(1)));

    // R4
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !out_last && !lin_mode && !unrestricted &&
         (cur_col != {{(SW-CW){1'b0}}, ext_w}))
            |=> (out_addr == $past(out_addr) + AW'(1)));

    // R3
    setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !out_valid));

endmodule

bind fwin_addr_gen fwin_addr_gen_chk #(.CW(CW), .AW(AW), .SW(SW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .stop         (stop),
    .lin_mode     (lin_mode),
    .unrestricted (unrestricted),
    .out_rdy      (out_rdy),
    .out_valid    (out_valid),
    .out_addr     (out_addr),
    .out_last     (out_last),
    .busy         (busy),
    .ext_w        (ext_w),
    .cur_col      (cur_col),
    .words_left   (words_left)
);

// File: tb/sim_fwin_addr_gen.sv
`timescale 1ns/1ps
module sim_fwin_addr_gen;
    localparam int CW = 10;
    localparam int BW = 12;
    localparam int AW = 24;
    localparam int SW = 2 * CW + 2;
    localparam int NV = 7;

    // vector table: mode, clamp, picture, start, extent, base, size, first address
    localparam int V_LIN[NV] = '{0, 1, 0, 0, 0, 1, 0};
    localparam int V_UNR[NV] = '{0, 0, 1, 1, 0, 1, 0};
    localparam int V_PW [NV] = '{9, 9, 9, 9, 4, 9, 7};
    localparam int V_PH [NV] = '{9, 9, 9, 9, 4, 9, 7};
    localparam int V_PSX[NV] = '{3, 15, -2, 8, 3, -5, 1};
    localparam int V_PSY[NV] = '{2, 1, -1, 8, 0, 20, 1};
    localparam int V_EW [NV] = '{3, 100, 2, 3, 3, 4, 0};
    localparam int V_EH [NV] = '{3, 1, 2, 3, 0, 0, 2};
    localparam int V_FB [NV] = '{64, 64, 0, 1, 2, 0, 0};
    localparam int V_SZ [NV] = '{16, 613, 9, 16, 4, 5, 3};
    localparam int V_FA [NV] = '{1047, 1049, 0, 104, 35, 90, 9};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, resume = 1'b0, stop = 1'b0;
    logic lin_mode = 1'b0, unrestricted = 1'b0;
    logic [CW-1:0] pic_w = '0, pic_h = '0, ext_w = '0, ext_h = '0, rsm_row = '0;
    logic signed [CW:0] pos_x = '0, pos_y = '0;
    logic [BW-1:0] fm_base = '0;
    logic [SW-1:0] rsm_col = '0, rsm_left = '0;
    logic out_rdy = 1'b0;
    logic out_valid, out_last, busy;
    logic [AW-1:0] out_addr;
    logic [SW-1:0] xfer_size, cur_col, words_left;
    logic [CW-1:0] cur_row;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    int c_lin, c_unr, c_pw, c_ph, c_psx, c_psy, c_ew, c_eh, c_fb;

    always #4 clk = ~clk;

    fwin_addr_gen #(.CW(CW), .BW(BW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .stop(stop),
        .lin_mode(lin_mode), .unrestricted(unrestricted),
        .pic_w(pic_w), .pic_h(pic_h), .pos_x(pos_x), .pos_y(pos_y),
        .ext_w(ext_w), .ext_h(ext_h), .fm_base(fm_base),
        .rsm_row(rsm_row), .rsm_col(rsm_col), .rsm_left(rsm_left),
        .out_rdy(out_rdy), .out_valid(out_valid), .out_addr(out_addr),
        .out_last(out_last), .xfer_size(xfer_size), .busy(busy),
        .cur_row(cur_row), .cur_col(cur_col), .words_left(words_left)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampi(int v, int hi, int en);
        if (en == 0) return v;
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    // closed-form address of word i
    function automatic int ref_addr(int i);
        int x, y;
        if (c_lin != 0) begin
            x = clampi(c_psx, c_pw, c_unr);
            y = clampi(c_psy, c_ph, c_unr);
            return c_fb * 16 + y * (c_pw + 1) + x + i;
        end
        x = clampi(c_psx + i % (c_ew + 1), c_pw, c_unr);
        y = clampi(c_psy + i / (c_ew + 1), c_ph, c_unr);
        return c_fb * 16 + y * (c_pw + 1) + x;
    endfunction

    task automatic apply_vec(input int v);
        c_lin = V_LIN[v]; c_unr = V_UNR[v]; c_pw = V_PW[v]; c_ph = V_PH[v];
        c_psx = V_PSX[v]; c_psy = V_PSY[v]; c_ew = V_EW[v]; c_eh = V_EH[v];
        c_fb = V_FB[v];
        lin_mode = c_lin[0]; unrestricted = c_unr[0];
        pic_w = c_pw[CW-1:0]; pic_h = c_ph[CW-1:0];
        pos_x = c_psx[CW:0]; pos_y = c_psy[CW:0];
        ext_w = c_ew[CW-1:0]; ext_h = c_eh[CW-1:0]; fm_base = c_fb[BW-1:0];
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // consume words k .. k+total-1; checks sequence, last flag, return to idle
    task automatic collect(input int k, input int total, input bit gaps,
                           input string tag, output int first_act);
        int n = 0, mism = 0, lbad = 0, cyc = 0, bad_a = 0, bad_e = 0;
        first_act = -1;
        while (cyc < 5000) begin
            @(negedge clk);
            out_rdy = gaps ? (cyc % 4 != 3) : 1'b1;
            cyc++;
            if (out_valid && out_rdy) begin
                if (n == 0) first_act = int'(out_addr);
                if (int'(out_addr) != ref_addr(k + n)) begin
                    if (mism == 0) begin bad_a = int'(out_addr); bad_e = ref_addr(k + n); end
                    mism++;
                end
                if (out_last != (n == total - 1)) lbad++;
                n++;
                if (out_last || n >= total) break;
            end
        end
        chk(mism == 0, tag, "address sequence", bad_a, bad_e);
        chk(lbad == 0 && n == total, "R6", "word count with last flag", n, total);
        @(negedge clk);
        out_rdy = 1'b0;
        chk(!busy && !out_valid, "R6", "idle after last", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int fa;
        int s_row, s_col, s_left;
        string tags[NV] = '{"R4", "R5", "R8", "R8", "R12", "R8", "R4"};

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!out_valid, "R1", "valid in reset", out_valid, 0);
        chk(!busy, "R1", "busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(words_left == 0 && !busy, "R1", "words_left after reset", words_left, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            apply_vec(v);
            @(negedge clk);
            chk(int'(xfer_size) == V_SZ[v], "R2", "transfer size", xfer_size, V_SZ[v]);
            pulse_start();
            collect(0, V_SZ[v], 1'b1, tags[v], fa);
            chk(fa == V_FA[v], "R3", "first address", fa, V_FA[v]);
        end

        // R3 latency and R7 hold
        apply_vec(0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy && !out_valid, "R3", "setup cycle", out_valid, 0);
        @(negedge clk);
        chk(out_valid && out_addr == 1047, "R3", "first word offered", out_addr, 1047);
        @(negedge clk);
        @(negedge clk);
        chk(out_valid && out_addr == 1047 && words_left == 16, "R7", "held while stalled",
            out_addr, 1047);
        // consume five words, then R11: start while busy is ignored
        for (int i = 0; i < 5; i++) begin
            out_rdy = 1'b1;
            @(negedge clk);
        end
        out_rdy = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy && words_left == 11 && int'(out_addr) == ref_addr(5), "R11",
            "start ignored while busy", words_left, 11);
        // one more word, then stop: R10 and R9 saved state
        out_rdy = 1'b1;
        @(negedge clk);
        out_rdy = 1'b1; stop = 1'b1;
        @(negedge clk);
        stop = 1'b0; out_rdy = 1'b0;
        chk(!busy && !out_valid, "R10", "stop returns to idle", busy, 0);
        chk(cur_row == 1 && cur_col == 2, "R9", "saved position row*16+col",
            cur_row * 16 + cur_col, 18);
        chk(words_left == 10, "R9", "saved remaining count", words_left, 10);
        s_row = int'(cur_row); s_col = int'(cur_col); s_left = int'(words_left);

        // another transfer in between
        apply_vec(4);
        pulse_start();
        collect(0, V_SZ[4], 1'b0, "R12", fa);

        // R10: zero count resume is ignored
        apply_vec(0);
        rsm_row = '0; rsm_col = '0; rsm_left = '0;
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
        chk(!busy, "R10", "resume with zero count ignored", busy, 0);

        // R10: resume continues the saved sequence from word 6
        rsm_row = s_row[CW-1:0]; rsm_col = s_col[SW-1:0]; rsm_left = s_left[SW-1:0];
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
        collect(6, 10, 1'b1, "R10", fa);
        chk(fa == ref_addr(6), "R10", "first address after resume", fa, ref_addr(6));

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule